// File: doc/BRIEF.md
# Switch Control Register with Deferred Reset Commands

This block is the 32-bit switch control register found at offset 0x404 of a configuration space. A requester reaches it through a small request/completion port: a request (read or write, address, data) is offered with `req_valid` and taken when `req_ready` is high. Every accepted request, whether or not it hits the register, produces one completion that is held on `cpl_valid`/`cpl_rdata` until `cpl_ready` takes it. Only one request is outstanding at a time. `req_ready` stays low while a completion waits, so a requester that stalls `cpl_ready` stalls the request side as well.

Two write-one command bits request a fundamental reset or a hot reset. The hot reset also asks for a link retrain. Neither command is stored. The request is armed when the write is accepted, and a delay counter of `DELAY_CYCLES` register clocks starts only once that write's completion has been handed back. When the count ends, a one-cycle pulse goes to the reset sequencer. The other bits are sticky policy and lock controls:
- a reset-halt flag, loaded from a pin or by the initialiser during a reset operation;
- a register-unlock flag, forced on during a reset operation, that opens lock-protected fields elsewhere;
- a power-budget unlock, which is itself lock-protected;
- a flag that suppresses hot resets caused by the link going down;
- a flag that makes the hot-reset sequence skip its EEPROM initialisation step.

Sticky bits survive `rst_n` and clear only on `por_n`. All non-sticky state clears on either reset, including a pending request and a waiting completion.

Top module: `swctl_reg`

## Requirements
- R1: Reads of bits 1:0 and bits 31:7 return 0, and writing those reserved bits changes nothing.
- R2: Writing 1 to bit 0 raises `fund_rst_pulse` for exactly one cycle. The pulse comes `DELAY_CYCLES` clocks after the clock edge at which that write's completion handshake occurs. Writing 0 to bit 0 produces no pulse.
- R3: Writing 1 to bit 1 raises `hot_rst_pulse` and `link_retrain_pulse` together for one cycle, with the same timing as R2.
- R4: The delay does not run while the completion of the command write is held back by `cpl_ready`. No pulse can appear before that handshake.
- R5: Only one request can be pending. Command bits in writes accepted while a request is pending are ignored. A write with both bits 0 and 1 set requests only a fundamental reset.
- R6: Bit 2 (reset halt, output `halt_hold`) is loaded from `halt_pin` in the first cycle `init_active` is high. While `init_active` is high, writes may change it. While `init_active` is low, writes leave it unchanged.
- R7: Bit 3 (register unlock, output `regs_unlocked`) is forced to 1 while `init_active` is high, and is freely written otherwise.
- R8: Bit 4 (power-budget unlock, output `pwr_budget_wr_en`) takes a written value only if bit 3 was 1 before that write. Otherwise it keeps its value.
- R9: Bits 5 and 6 are read/write and drive `dl_down_hrst_dis` and `skip_eeprom_init`.
- R10: Bits 6:2 keep their values through `rst_n` and return to 0 on `por_n`.
- R11: Asserting `rst_n` (or `por_n`) low cancels a pending reset request, so no pulse follows.
- R12: A completion holds `cpl_valid` and `cpl_rdata` stable until `cpl_ready`, with `req_ready` low meanwhile. A request to any address other than `REG_OFFSET` is completed with read data 0 and has no other effect.
- R13: After power-on reset, every output pulse and control output is 0, no completion is pending, and the register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; clears everything |
| rst_n | input | 1 | Any other reset, active low, synchronous; clears non-sticky state |
| init_active | input | 1 | High while a reset operation / initialisation is in progress |
| halt_pin | input | 1 | External reset-halt strap, sampled when `init_active` rises |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken when high together with `req_valid` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | 32 | Write data |
| cpl_valid | output | 1 | Completion available |
| cpl_ready | input | 1 | Completion taken when high together with `cpl_valid` |
| cpl_rdata | output | 32 | Read data of the completion (0 for writes and misses) |
| fund_rst_pulse | output | 1 | One-cycle fundamental-reset request |
| hot_rst_pulse | output | 1 | One-cycle hot-reset request |
| link_retrain_pulse | output | 1 | One-cycle upstream link retrain request, with the hot reset |
| halt_hold | output | 1 | Reset-halt flag to the reset sequencer |
| regs_unlocked | output | 1 | Lock-protected fields elsewhere may be written |
| pwr_budget_wr_en | output | 1 | Power budgeting data value registers are writable |
| dl_down_hrst_dis | output | 1 | Suppress hot reset caused by link-down |
| skip_eeprom_init | output | 1 | Hot reset skips its EEPROM initialisation step |

## Verification
On every cycle, the assertions check four things:
- the completion is held steady under back-pressure, and reads show zero in the reserved and command positions;
- the request pulses are single-cycle and never both at once, and none comes while a request is still waiting for its completion;
- the unlock is forced during initialisation;
- reset halt and power-budget unlock cannot change when their write conditions are absent.

Only the bench scenarios can show the rest. These are the exact delay measured from the completion handshake, the dropping of a second command while one is pending, the cancellation by a hot reset, sticky retention against power-on clearing, and the read-back of field values over mixed random traffic.

// File: rtl/swctl_pkg.sv
package swctl_pkg;

  localparam int REG_W = 32;

  // bit positions inside the control word (software decodes them)
  localparam int B_FRST = 0;
  localparam int B_HRST = 1;
  localparam int B_HALT = 2;
  localparam int B_UNLK = 3;
  localparam int B_PBUL = 4;
  localparam int B_DLDH = 5;
  localparam int B_SKEE = 6;

  typedef enum logic [1:0] {
    DF_IDLE     = 2'd0,
    DF_WAIT_CPL = 2'd1,
    DF_COUNT    = 2'd2
  } defer_state_e;

  typedef enum logic {
    KIND_FUND = 1'b0,
    KIND_HOT  = 1'b1
  } reset_kind_e;

  typedef struct packed {
    logic skip_ee;
    logic dl_hrst_dis;
    logic pwr_unlk;
    logic unlk;
    logic halt;
  } sticky_t;

endpackage

// File: rtl/swctl_port.sv
module swctl_port
  import swctl_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h404
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              cpl_ready,
  output logic              cpl_valid,
  output logic [REG_W-1:0]  cpl_rdata,
  input  logic [REG_W-1:0]  rd_image,
  output logic              wr_hit,
  output logic              cpl_done
);

  logic accept;
  logic hit;

  assign req_ready = !cpl_valid;
  assign accept    = req_valid && req_ready;
  assign hit       = (req_addr == REG_OFFSET);
  assign wr_hit    = accept && req_write && hit;
  assign cpl_done  = cpl_valid && cpl_ready;

  always_ff @(posedge clk) begin
    if (!clr_n) begin
      cpl_valid <= 1'b0;
      cpl_rdata <= '0;
    end else if (accept) begin
      cpl_valid <= 1'b1;
      cpl_rdata <= (!req_write && hit) ? rd_image : '0;
    end else if (cpl_done) begin
      cpl_valid <= 1'b0;
    end
  end

  AST_CPL_HOLD: assert property (@(posedge clk) disable iff (!clr_n)
    cpl_valid && !cpl_ready |=> cpl_valid && $stable(cpl_rdata)) else $error("cpl hold"); // R12

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!clr_n)
    cpl_valid |-> (cpl_rdata[B_HRST:B_FRST] == 2'b00) && (cpl_rdata[REG_W-1:B_SKEE+1] == '0)) else $error("rsvd"); // R1

endmodule

// File: rtl/swctl_fields.sv
module swctl_fields
  import swctl_pkg::*;
(
  input  logic               clk,
  input  logic               por_n,
  input  logic               init_active,
  input  logic               halt_pin,
  input  logic               wr_en,
  input  logic [B_SKEE:B_HALT] wr_bits,
  output sticky_t            st,
  output logic [REG_W-1:0]   rd_image
);

  logic init_q;
  logic init_rise;

  assign init_rise = init_active && !init_q;

  always_ff @(posedge clk) begin
    if (!por_n) begin
      st     <= '0;
      init_q <= 1'b0;
    end else begin
      init_q <= init_active;

      // unlock: forced during a reset operation, plain RW otherwise
      if (init_active)
        st.unlk <= 1'b1;
      else if (wr_en)
        st.unlk <= wr_bits[B_UNLK];

      // reset halt: strap capture, then writable only while initialising
      if (init_rise)
        st.halt <= halt_pin;
      else if (init_active && wr_en)
        st.halt <= wr_bits[B_HALT];

      // power budget unlock is itself lock-protected
      if (wr_en && st.unlk)
        st.pwr_unlk <= wr_bits[B_PBUL];

      if (wr_en) begin
        st.dl_hrst_dis <= wr_bits[B_DLDH];
        st.skip_ee     <= wr_bits[B_SKEE];
      end
    end
  end

  always_comb begin
    rd_image         = '0;
    rd_image[B_HALT] = st.halt;
    rd_image[B_UNLK] = st.unlk;
    rd_image[B_PBUL] = st.pwr_unlk;
    rd_image[B_DLDH] = st.dl_hrst_dis;
    rd_image[B_SKEE] = st.skip_ee;
  end

  AST_INIT_UNLOCK: assert property (@(posedge clk) disable iff (!por_n)
    init_active |=> st.unlk) else $error("init unlock"); // R7

  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!por_n)
    $past(por_n) && !$past(init_active) |-> $stable(st.halt)) else $error("halt frozen"); // R6

  AST_PWR_LOCKED: assert property (@(posedge clk) disable iff (!por_n)
    $past(por_n) && !$past(st.unlk) |-> $stable(st.pwr_unlk)) else $error("pwr locked"); // R8

endmodule

// File: rtl/swctl_defer.sv
module swctl_defer
  import swctl_pkg::*;
#(
  parameter int DELAY_CYCLES = 100000
) (
  input  logic clk,
  input  logic clr_n,
  input  logic cmd_fund,
  input  logic cmd_hot,
  input  logic cpl_done,
  output logic fund_pulse,
  output logic hot_pulse,
  output logic retrain_pulse
);

  localparam int CNT_W = (DELAY_CYCLES > 1) ? $clog2(DELAY_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DELAY_CYCLES - 1);

  defer_state_e state;
  reset_kind_e  kind;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!clr_n) begin
      state         <= DF_IDLE;
      kind          <= KIND_FUND;
      cnt           <= '0;
      fund_pulse    <= 1'b0;
      hot_pulse     <= 1'b0;
      retrain_pulse <= 1'b0;
    end else begin
      fund_pulse    <= 1'b0;
      hot_pulse     <= 1'b0;
      retrain_pulse <= 1'b0;
      unique case (state)
        DF_IDLE: begin
          if (cmd_fund) begin
            kind  <= KIND_FUND;
            state <= DF_WAIT_CPL;
          end else if (cmd_hot) begin
            kind  <= KIND_HOT;
            state <= DF_WAIT_CPL;
          end
        end
        DF_WAIT_CPL: begin
          if (cpl_done) begin
            cnt   <= CNT_LOAD;
            state <= DF_COUNT;
          end
        end
        DF_COUNT: begin
          if (cnt == '0) begin
            state <= DF_IDLE;
            if (kind == KIND_FUND) begin
              fund_pulse <= 1'b1;
            end else begin
              hot_pulse     <= 1'b1;
              retrain_pulse <= 1'b1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= DF_IDLE;
      endcase
    end
  end

  AST_FUND_SINGLE: assert property (@(posedge clk) disable iff (!clr_n)
    fund_pulse |=> !fund_pulse) else $error("fund single"); // R2

  AST_HOT_SINGLE: assert property (@(posedge clk) disable iff (!clr_n)
    hot_pulse |=> !hot_pulse) else $error("hot single"); // R3

  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!clr_n)
    !(fund_pulse && hot_pulse)) else $error("one kind"); // R5

  AST_NO_FIRE_WAITING: assert property (@(posedge clk) disable iff (!clr_n)
    state == DF_WAIT_CPL |=> !fund_pulse && !hot_pulse) else $error("early fire"); // R4

endmodule

// File: rtl/swctl_reg.sv
module swctl_reg
  import swctl_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h404,
  parameter int DELAY_CYCLES = 100000
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              init_active,
  input  logic              halt_pin,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              cpl_valid,
  input  logic              cpl_ready,
  output logic [31:0]       cpl_rdata,
  output logic              fund_rst_pulse,
  output logic              hot_rst_pulse,
  output logic              link_retrain_pulse,
  output logic              halt_hold,
  output logic              regs_unlocked,
  output logic              pwr_budget_wr_en,
  output logic              dl_down_hrst_dis,
  output logic              skip_eeprom_init
);

  logic                 clr_n;
  logic                 wr_hit;
  logic                 cpl_done;
  logic [REG_W-1:0]     rd_image;
  logic [B_SKEE:B_HALT] wr_bits;
  logic                 rsvd_unused;
  sticky_t              st;

  assign clr_n       = rst_n && por_n;
  assign wr_bits     = req_wdata[B_SKEE:B_HALT];
  assign rsvd_unused = ^req_wdata[REG_W-1:B_SKEE+1];

  swctl_port #(
    .ADDR_W     (ADDR_W),
    .REG_OFFSET (REG_OFFSET)
  ) u_port (
    .clk       (clk),
    .clr_n     (clr_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .cpl_ready (cpl_ready),
    .cpl_valid (cpl_valid),
    .cpl_rdata (cpl_rdata),
    .rd_image  (rd_image),
    .wr_hit    (wr_hit),
    .cpl_done  (cpl_done)
  );

  swctl_fields u_fields (
    .clk         (clk),
    .por_n       (por_n),
    .init_active (init_active),
    .halt_pin    (halt_pin),
    .wr_en       (wr_hit),
    .wr_bits     (wr_bits),
    .st          (st),
    .rd_image    (rd_image)
  );

  swctl_defer #(
    .DELAY_CYCLES (DELAY_CYCLES)
  ) u_defer (
    .clk           (clk),
    .clr_n         (clr_n),
    .cmd_fund      (wr_hit && req_wdata[B_FRST]),
    .cmd_hot       (wr_hit && req_wdata[B_HRST]),
    .cpl_done      (cpl_done),
    .fund_pulse    (fund_rst_pulse),
    .hot_pulse     (hot_rst_pulse),
    .retrain_pulse (link_retrain_pulse)
  );

  assign halt_hold        = st.halt;
  assign regs_unlocked    = st.unlk;
  assign pwr_budget_wr_en = st.pwr_unlk;
  assign dl_down_hrst_dis = st.dl_hrst_dis;
  assign skip_eeprom_init = st.skip_ee;

  AST_RETRAIN_WITH_HOT: assert property (@(posedge clk) disable iff (!clr_n)
    link_retrain_pulse |-> hot_rst_pulse) else $error("retrain"); // R3

endmodule

// File: tb/swctl_reg_bench.sv
module swctl_reg_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DLY        = 12;
  localparam int ADDR_W     = 12;
  localparam logic [ADDR_W-1:0] OFF = 12'h404;
  localparam int WD_LIMIT   = 100000;

  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b0, init_active = 1'b0, halt_pin = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, cpl_ready = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, cpl_valid;
  logic [31:0] cpl_rdata;
  logic fund_rst_pulse, hot_rst_pulse, link_retrain_pulse;
  logic halt_hold, regs_unlocked, pwr_budget_wr_en, dl_down_hrst_dis, skip_eeprom_init;

  int total = 0, bad = 0, cyc = 0;
  int n_fund = 0, n_hot = 0, n_rtr = 0;
  logic [31:0] m = '0;
  logic [31:0] rd;

  swctl_reg #(.ADDR_W(ADDR_W), .REG_OFFSET(OFF), .DELAY_CYCLES(DLY)) u_swctl_reg (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .init_active(init_active), .halt_pin(halt_pin),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_rdata(cpl_rdata),
    .fund_rst_pulse(fund_rst_pulse), .hot_rst_pulse(hot_rst_pulse),
    .link_retrain_pulse(link_retrain_pulse), .halt_hold(halt_hold), .regs_unlocked(regs_unlocked),
    .pwr_budget_wr_en(pwr_budget_wr_en), .dl_down_hrst_dis(dl_down_hrst_dis),
    .skip_eeprom_init(skip_eeprom_init)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (fund_rst_pulse) n_fund++;
    if (hot_rst_pulse) n_hot++;
    if (link_retrain_pulse) n_rtr++;
    cyc++;
    if (cyc > WD_LIMIT) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cyc, WD_LIMIT);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // field image after a write; bits 6:2 only, reserved and command bits stay 0
  function automatic logic [31:0] next_img(logic [31:0] cur, logic [31:0] wd, bit init);
    logic [31:0] n = cur;
    n[3] = init ? 1'b1 : wd[3];
    if (init) n[2] = wd[2];
    if (cur[3]) n[4] = wd[4];
    n[5] = wd[5];
    n[6] = wd[6];
    return n;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one request; returns at the falling edge after the completion handshake
  task automatic xfer(bit wr, logic [ADDR_W-1:0] a, logic [31:0] d, int hold, output logic [31:0] r);
    logic [31:0] first;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    first = cpl_rdata;
    repeat (hold) @(negedge clk);
    if (hold > 0) begin
      check("R12 completion held", {30'd0, cpl_valid, req_ready}, 32'h2);
      check("R12 rdata stable", cpl_rdata, first);
    end
    cpl_ready = 1'b1;
    r = cpl_rdata;
    @(posedge clk);
    @(negedge clk);
    cpl_ready = 1'b0;
  endtask

  task automatic wr_model(logic [31:0] d, bit init);
    logic [31:0] dummy;
    xfer(1'b1, OFF, d, 0, dummy);
    m = next_img(m, d, init);
  endtask

  // called right after a command write completes
  task automatic expect_pulse(bit hot, string tag);
    bit early = 1'b0;
    for (int i = 1; i <= DLY; i++) begin
      if (i > 1) @(negedge clk);
      if (fund_rst_pulse || hot_rst_pulse || link_retrain_pulse) early = 1'b1;
    end
    check({tag, " no early pulse (R4)"}, {31'd0, early}, 32'd0);
    @(negedge clk);
    check({tag, " pulse"}, {29'd0, fund_rst_pulse, hot_rst_pulse, link_retrain_pulse},
          hot ? 32'h3 : 32'h4);
    @(negedge clk);
    check({tag, " pulse ends"}, {29'd0, fund_rst_pulse, hot_rst_pulse, link_retrain_pulse}, 32'd0);
  endtask

  initial begin
    int f0, h0;
    void'($urandom(32'd2718));
    repeat (4) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    check("R13 outputs", {22'd0, fund_rst_pulse, hot_rst_pulse, link_retrain_pulse, halt_hold,
          regs_unlocked, pwr_budget_wr_en, dl_down_hrst_dis, skip_eeprom_init, cpl_valid, !req_ready}, 32'd0);
    xfer(1'b0, OFF, 0, 0, rd);
    check("R13 read", rd, 32'd0);

    // R2 fundamental reset command
    xfer(1'b1, OFF, 32'h1, 0, rd);
    expect_pulse(1'b0, "R2 fund");
    f0 = n_fund; h0 = n_hot;
    xfer(1'b1, OFF, 32'h0, 0, rd);
    repeat (3*DLY) @(negedge clk);
    check("R2 write zero no pulse", n_fund + n_hot, f0 + h0);

    // R3 hot reset plus retrain
    xfer(1'b1, OFF, 32'h2, 0, rd);
    expect_pulse(1'b1, "R3 hot");
    check("R3 retrain count matches hot", n_rtr, n_hot);

    // R4 delay starts after the completion handshake
    f0 = n_fund;
    xfer(1'b1, OFF, 32'h1, 3*DLY, rd);
    check("R4 no pulse while completion held", n_fund, f0);
    expect_pulse(1'b0, "R4 fund held");

    // R5 both bits: fundamental only
    xfer(1'b1, OFF, 32'h3, 0, rd);
    expect_pulse(1'b0, "R5 both bits");
    // R5 second command while pending is dropped
    f0 = n_fund; h0 = n_hot;
    xfer(1'b1, OFF, 32'h2, 0, rd);
    xfer(1'b1, OFF, 32'h1, 0, rd);
    repeat (3*DLY) @(negedge clk);
    check("R5 pending hot fired", n_hot - h0, 1);
    check("R5 later fund dropped", n_fund - f0, 0);

    // R1 reserved bits
    wr_model(32'hFFFF_FF80, 1'b0);
    xfer(1'b0, OFF, 0, 0, rd);
    check("R1 reserved read zero", rd, 32'd0);

    // R6/R7 initialisation sequence
    halt_pin = 1'b1;
    @(negedge clk); init_active = 1'b1;
    m[2] = 1'b1; m[3] = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 halt strap captured", {31'd0, halt_hold}, 32'd1);
    check("R7 unlock forced", {31'd0, regs_unlocked}, 32'd1);
    wr_model(32'h0, 1'b1);
    check("R6 halt written during init", {31'd0, halt_hold}, 32'd0);
    check("R7 unlock stays during init", {31'd0, regs_unlocked}, 32'd1);
    wr_model(32'h4, 1'b1);
    check("R6 halt set during init", {31'd0, halt_hold}, 32'd1);
    @(negedge clk); init_active = 1'b0; halt_pin = 1'b0;
    wr_model(32'h0, 1'b0);
    check("R6 halt ignores write", {31'd0, halt_hold}, 32'd1);
    check("R7 unlock cleared", {31'd0, regs_unlocked}, 32'd0);

    // R8 power budget unlock gated
    wr_model(32'h18, 1'b0);
    check("R8 locked write ignored", {31'd0, pwr_budget_wr_en}, 32'd0);
    wr_model(32'h18, 1'b0);
    check("R8 unlocked write taken", {31'd0, pwr_budget_wr_en}, 32'd1);
    wr_model(32'h00, 1'b0);
    check("R8 cleared while unlocked", {31'd0, pwr_budget_wr_en}, 32'd0);
    wr_model(32'h18, 1'b0);
    wr_model(32'h10, 1'b0);
    wr_model(32'h00, 1'b0);
    check("R8 held while locked", {31'd0, pwr_budget_wr_en}, 32'd1);

    // R9 policy bits
    wr_model(32'h60, 1'b0);
    check("R9 outputs", {30'd0, dl_down_hrst_dis, skip_eeprom_init}, 32'h3);
    xfer(1'b0, OFF, 0, 0, rd);
    check("R9 read back", rd, m);

    // R12 wrong address
    f0 = n_fund;
    xfer(1'b1, OFF + 12'h4, 32'h7F, 0, rd);
    xfer(1'b0, OFF + 12'h4, 0, 2, rd);
    check("R12 miss reads zero", rd, 32'd0);
    xfer(1'b0, OFF, 0, 0, rd);
    check("R12 miss left register", rd, m);
    repeat (2*DLY) @(negedge clk);
    check("R12 miss no command", n_fund, f0);

    // R11 reset cancels pending request; R10 sticky retention
    h0 = n_hot;
    xfer(1'b1, OFF, 32'h2 | m, 0, rd);
    m = next_img(m, 32'h2 | m, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3*DLY) @(negedge clk);
    check("R11 cancelled hot", n_hot - h0, 0);
    xfer(1'b0, OFF, 0, 0, rd);
    check("R10 sticky through rst_n", rd, m);

    // random traffic
    for (int k = 0; k < 60; k++) begin
      bit w = $urandom % 2;
      bit miss = ($urandom % 4) == 0;
      logic [ADDR_W-1:0] a = miss ? ADDR_W'(OFF ^ (($urandom % 255 + 1) << 2)) : OFF;
      logic [31:0] d = $urandom & 32'hFFFF_FFFC;
      int hold = $urandom % 4;
      xfer(w, a, d, hold, rd);
      if (w && !miss) m = next_img(m, d, 1'b0);
      if (!w) check(miss ? "R12 random miss" : "R1 random read", rd, miss ? 32'd0 : m);
    end

    // R10 power-on clears sticky
    @(negedge clk); por_n = 1'b0;
    repeat (2) @(negedge clk); por_n = 1'b1;
    m = '0;
    xfer(1'b0, OFF, 0, 0, rd);
    check("R10 por clears", rd, 32'd0);
    check("R10 outputs cleared", {27'd0, halt_hold, regs_unlocked, pwr_budget_wr_en,
          dl_down_hrst_dis, skip_eeprom_init}, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule